// File: doc/BRIEF.md
# NAND Bus Cycle Sequencer

This block produces one byte-wide bus cycle at a time toward a raw 8-bit NAND flash device. A request carries a kind (command, address or data), a direction and a write byte. The sequencer then drives chip-enable, the two latch-enable lines, the write or read strobe and the data bus through four timed phases: setup, strobe-active, hold and an optional ready wait. A one-clock done pulse marks the end of the cycle. For reads, the captured byte is presented on the read-data output.

Reads and writes each have their own clock counts, packed into one 32-bit timing word. A force bit keeps chip-enable asserted between cycles, so that a multi-cycle command sequence stays selected. A status output follows the device ready/busy line. A software-reset input aborts any cycle and clears the stored configuration.

Top module: `nand_cycle_seq`

## Requirements
- R1: After `rst`, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale`, `nand_dq_oe` and `done` are 0, and `req_ready` is 1.
- R2: The setup phase lasts (field + 1) clocks. The read setup field is timing bits [3:0] and the write setup field is bits [19:16]. During setup both strobes are high.
- R3: The strobe-active phase lasts (field + 1) clocks, with `nand_re_n` low on reads and `nand_we_n` low on writes. The read width field is bits [11:8] and the write width field is bits [27:24]. The two strobes are never low together.
- R4: The hold phase lasts (field + 1) clocks after the strobe rises. The read hold field is bits [7:4] and the write hold field is bits [23:20].
- R5: A ready-wait field n (read bits [15:12], write bits [31:28]) greater than 0 adds 2*n clocks after hold. The cycle then finishes only once the synchronized ready line reads 1. With n = 0 the ready line is not consulted.
- R6: `req_kind` code 1 (command) raises `nand_cle`, code 2 (address) raises `nand_ale`, and code 0 (data) raises neither. The latch line is held from the first setup clock to the last hold clock.
- R7: On a write, `nand_dq_oe` is 1 and `nand_dq_o` carries the request byte from the first setup clock to the last hold clock. Otherwise `nand_dq_oe` is 0.
- R8: On a read, `rd_data` takes the value of `nand_dq_i` on the last clock of the strobe-active phase. It keeps that value afterwards.
- R9: `done` is a single-clock pulse in the clock after the last phase. `req_ready` is 1 only while idle, and a request made while busy is ignored.
- R10: `nand_ce_n` is 0 throughout a cycle and whenever the force bit is 1. It is 1 when idle with the force bit clear.
- R11: `ready_stat` is the `nand_rdy` level (1 = ready) delayed by a two-flop synchronizer.
- R12: `soft_rst` returns the sequencer to idle on the next clock and clears the timing word and force bit to zero, so every phase then lasts 1 clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Abort the cycle and clear the configuration |
| cfg_wr | input | 1 | Load the timing word and force bit |
| cfg_timing | input | 32 | Eight 4-bit phase counts |
| cfg_ce_force | input | 1 | Hold chip-enable asserted |
| req_valid | input | 1 | Request a bus cycle |
| req_kind | input | 2 | 0 data, 1 command, 2 address |
| req_rd | input | 1 | 1 read, 0 write |
| req_data | input | 8 | Write byte |
| req_ready | output | 1 | Idle, request accepted |
| done | output | 1 | Cycle finished pulse |
| rd_data | output | 8 | Captured read byte |
| ready_stat | output | 1 | Synchronized device ready level |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rdy | input | 1 | Device ready/busy, 1 = ready |

## Verification
The hardest state to reach is the poll after a ready wait, with the device still busy. It occurs only when the ready line is already low by the time the wait counter expires. The stimulus drops `nand_rdy` and waits for `ready_stat` to fall before issuing a write with a one-count wait. It then holds the line low well past the wait and confirms that `done` stays low. Finally it releases the line and expects `done` exactly three clocks later, which covers the two synchronizer stages plus the poll decision. Phase lengths are measured at the pins for the extreme field values 0 and 15 and for random values.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int FIELD_W  = 4;
    localparam int HALF_W   = 4 * FIELD_W;
    localparam int TIMING_W = 2 * HALF_W;
    localparam int CNT_W    = FIELD_W + 1;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_CMD  = 2'd1,
        KIND_ADDR = 2'd2,
        KIND_RSVD = 2'd3
    } nand_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_WAIT,
        ST_POLL
    } seq_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] setup;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] width;
        logic [FIELD_W-1:0] rwait;
    } phase_tim_t;

    // Ready wait of 2*n clocks expressed as a down-counter load value.
    function automatic logic [CNT_W-1:0] wait_load(input logic [FIELD_W-1:0] n);
        return {n, 1'b0} - CNT_W'(1);
    endfunction

endpackage

// File: rtl/nand_tim_sel.sv
module nand_tim_sel
    import nand_seq_pkg::*;
(
    input  logic [TIMING_W-1:0] timing,
    input  logic                rd,
    output phase_tim_t          tim
);
    phase_tim_t half [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam int B = h * HALF_W;
        assign half[h] = {timing[B             +: FIELD_W],
                          timing[B + FIELD_W   +: FIELD_W],
                          timing[B + 2*FIELD_W +: FIELD_W],
                          timing[B + 3*FIELD_W +: FIELD_W]};
    end

    assign tim = rd ? half[0] : half[1];

endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer
    import nand_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)       cnt <= '0;
        else if (load)        cnt <= val;
        else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
    end

    assign zero = (cnt == '0);

    // R5
    timer_rest_chk: assert property (@(posedge clk) disable iff (rst)
        (zero && !load && !clr) |=> zero);

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                soft_rst,
    input  logic                cfg_wr,
    input  logic [TIMING_W-1:0] cfg_timing,
    input  logic                cfg_ce_force,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic                req_rd,
    input  logic [DATA_W-1:0]   req_data,
    output logic                req_ready,
    output logic                done,
    output logic [DATA_W-1:0]   rd_data,
    output logic                ready_stat,
    output logic                nand_ce_n,
    output logic                nand_cle,
    output logic                nand_ale,
    output logic                nand_we_n,
    output logic                nand_re_n,
    output logic [DATA_W-1:0]   nand_dq_o,
    output logic                nand_dq_oe,
    input  logic [DATA_W-1:0]   nand_dq_i,
    input  logic                nand_rdy
);
    seq_state_e          state;
    logic [TIMING_W-1:0] timing_q;
    logic                force_q;
    nand_kind_e          kind_q;
    logic                rd_q;
    logic [DATA_W-1:0]   wdata_q;
    phase_tim_t          tim;
    logic                tmr_load;
    logic [CNT_W-1:0]    tmr_val;
    logic                tmr_zero;
    logic [SYNC_STAGES-1:0] rdy_sync;
    logic                rdy_s;
    logic                in_xfer;

    // Ready/busy synchronizer
    always_ff @(posedge clk) begin
        if (rst) rdy_sync <= '0;
        else     rdy_sync <= {rdy_sync[SYNC_STAGES-2:0], nand_rdy};
    end
    assign rdy_s      = rdy_sync[SYNC_STAGES-1];
    assign ready_stat = rdy_s;

    nand_tim_sel i_tim_sel (
        .timing (timing_q),
        .rd     ((state == ST_IDLE) ? req_rd : rd_q),
        .tim    (tim)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE:   if (req_valid) begin
                           tmr_load = 1'b1; tmr_val = CNT_W'(tim.setup);
                       end
            ST_SETUP:  if (tmr_zero) begin
                           tmr_load = 1'b1; tmr_val = CNT_W'(tim.width);
                       end
            ST_STROBE: if (tmr_zero) begin
                           tmr_load = 1'b1; tmr_val = CNT_W'(tim.hold);
                       end
            ST_HOLD:   if (tmr_zero && tim.rwait != '0) begin
                           tmr_load = 1'b1; tmr_val = wait_load(tim.rwait);
                       end
            default:   ;
        endcase
    end

    nand_phase_timer i_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (soft_rst),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state    <= ST_IDLE;
            timing_q <= '0;
            force_q  <= 1'b0;
            kind_q   <= KIND_DATA;
            rd_q     <= 1'b0;
            wdata_q  <= '0;
            rd_data  <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cfg_wr) begin
                timing_q <= cfg_timing;
                force_q  <= cfg_ce_force;
            end
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    kind_q  <= nand_kind_e'(req_kind);
                    rd_q    <= req_rd;
                    wdata_q <= req_data;
                    state   <= ST_SETUP;
                end
                ST_SETUP: if (tmr_zero) state <= ST_STROBE;
                ST_STROBE: if (tmr_zero) begin
                    if (rd_q) rd_data <= nand_dq_i;
                    state <= ST_HOLD;
                end
                ST_HOLD: if (tmr_zero) begin
                    if (tim.rwait != '0) state <= ST_WAIT;
                    else begin state <= ST_IDLE; done <= 1'b1; end
                end
                ST_WAIT: if (tmr_zero) begin
                    if (rdy_s) begin state <= ST_IDLE; done <= 1'b1; end
                    else       state <= ST_POLL;
                end
                ST_POLL: if (rdy_s) begin state <= ST_IDLE; done <= 1'b1; end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign in_xfer    = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    assign req_ready  = (state == ST_IDLE);
    assign nand_ce_n  = !(force_q || state != ST_IDLE);
    assign nand_cle   = in_xfer && (kind_q == KIND_CMD);
    assign nand_ale   = in_xfer && (kind_q == KIND_ADDR);
    assign nand_we_n  = !((state == ST_STROBE) && !rd_q);
    assign nand_re_n  = !((state == ST_STROBE) && rd_q);
    assign nand_dq_oe = in_xfer && !rd_q;
    assign nand_dq_o  = wdata_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6
    latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nand_cle, nand_ale}));
    // R7
    oe_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        nand_dq_oe |-> nand_re_n);
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        nand_we_n || nand_re_n);
    // R10
    strobe_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    // R12
    soft_idle_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (req_ready && !done && nand_we_n && nand_re_n && !nand_dq_oe));

endmodule

// File: tb/test_nand_cycle_seq.sv
module test_nand_cycle_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        soft_rst = 0;
    logic        cfg_wr = 0;
    logic [31:0] cfg_timing = '0;
    logic        cfg_ce_force = 0;
    logic        req_valid = 0;
    logic [1:0]  req_kind = 0;
    logic        req_rd = 0;
    logic [7:0]  req_data = 0;
    logic        req_ready, done, ready_stat;
    logic [7:0]  rd_data, nand_dq_o;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_i = 0;
    logic        nand_rdy = 1;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_cycle_seq i_nand_cycle_seq (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
        .cfg_timing(cfg_timing), .cfg_ce_force(cfg_ce_force),
        .req_valid(req_valid), .req_kind(req_kind), .req_rd(req_rd),
        .req_data(req_data), .req_ready(req_ready), .done(done),
        .rd_data(rd_data), .ready_stat(ready_stat), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i), .nand_rdy(nand_rdy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] tword(input int rs, rh, rw, rn, ws, wh, ww, wn);
        return {wn[3:0], ww[3:0], wh[3:0], ws[3:0], rn[3:0], rw[3:0], rh[3:0], rs[3:0]};
    endfunction

    task automatic do_cfg(input logic [31:0] t, input logic f);
        @(negedge clk);
        cfg_timing = t; cfg_ce_force = f; cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic run_cycle(input logic [1:0] kind, input logic rd,
                             input logic [7:0] wd, input logic [7:0] rdv,
                             output int pre, output int w, output int post,
                             output int oe_n, output int cle_n, output int ale_n,
                             output int ce_bad, output int dq_bad);
        int guard;
        bit seen;
        bit strobe;
        pre = 0; w = 0; post = 0; oe_n = 0; cle_n = 0; ale_n = 0;
        ce_bad = 0; dq_bad = 0; guard = 0; seen = 0;
        @(negedge clk);
        req_kind = kind; req_rd = rd; req_data = wd; req_valid = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        while (!done && guard < 400) begin
            strobe = rd ? !nand_re_n : !nand_we_n;
            if (!seen && !strobe) pre++;
            else if (strobe) begin w++; seen = 1; end
            else post++;
            oe_n  += int'(nand_dq_oe);
            cle_n += int'(nand_cle);
            ale_n += int'(nand_ale);
            if (nand_ce_n) ce_bad++;
            if (nand_dq_oe && nand_dq_o != wd) dq_bad++;
            nand_dq_i = !nand_re_n ? rdv : ~rdv;
            guard++;
            @(negedge clk);
        end
        check(guard < 400, "R9 done reached", guard, 0);
    endtask

    task automatic t_reset();
        check(nand_ce_n == 1 && nand_we_n == 1 && nand_re_n == 1, "R1 strobes/ce idle",
              {nand_ce_n, nand_we_n, nand_re_n}, 7);
        check(!nand_cle && !nand_ale && !nand_dq_oe && !done, "R1 latches/oe/done low",
              {nand_cle, nand_ale, nand_dq_oe, done}, 0);
        check(req_ready == 1, "R1 req_ready", req_ready, 1);
        check(nand_ce_n == 1, "R10 ce high when idle", nand_ce_n, 1);
    endtask

    task automatic t_write(input int ws, wh, ww, wn, input logic [1:0] kind);
        int pre, w, post, oe, cl, al, ceb, dqb, lat;
        logic [7:0] wd;
        wd = 8'($urandom_range(0, 255));
        do_cfg(tword($urandom_range(0,15), $urandom_range(0,15), $urandom_range(0,15),
                     $urandom_range(0,15), ws, wh, ww, wn), 0);
        run_cycle(kind, 0, wd, 8'h00, pre, w, post, oe, cl, al, ceb, dqb);
        check(pre == ws + 1, "R2 write setup", pre, ws + 1);
        check(w == ww + 1, "R3 write width", w, ww + 1);
        check(post == wh + 1 + 2*wn, "R4 R5 write hold+wait", post, wh + 1 + 2*wn);
        lat = ws + ww + wh + 3;
        check(oe == lat, "R7 write oe span", oe, lat);
        check(dqb == 0, "R7 write data value", dqb, 0);
        check(ceb == 0, "R10 ce low in cycle", ceb, 0);
        if (kind == 2'd1) begin
            check(cl == lat && al == 0, "R6 command latch", cl, lat);
        end else if (kind == 2'd2) begin
            check(al == lat && cl == 0, "R6 address latch", al, lat);
        end else begin
            check(al == 0 && cl == 0, "R6 data no latch", al + cl, 0);
        end
        @(negedge clk);
        check(done == 0, "R9 done single pulse", done, 0);
    endtask

    task automatic t_read(input int rs, rh, rw, rn);
        int pre, w, post, oe, cl, al, ceb, dqb;
        logic [7:0] rv;
        rv = 8'($urandom_range(0, 255));
        do_cfg(tword(rs, rh, rw, rn, $urandom_range(0,15), $urandom_range(0,15),
                     $urandom_range(0,15), $urandom_range(0,15)), 0);
        run_cycle(2'd0, 1, 8'h00, rv, pre, w, post, oe, cl, al, ceb, dqb);
        check(pre == rs + 1, "R2 read setup", pre, rs + 1);
        check(w == rw + 1, "R3 read width", w, rw + 1);
        check(post == rh + 1 + 2*rn, "R4 R5 read hold+wait", post, rh + 1 + 2*rn);
        check(oe == 0 && cl == 0 && al == 0, "R7 R6 read no drive/latch", oe + cl + al, 0);
        check(rd_data == rv, "R8 read capture", rd_data, rv);
        @(negedge clk);
        check(rd_data == rv, "R8 read data held", rd_data, rv);
    endtask

    task automatic t_busy_ignore();
        int dn;
        do_cfg(tword(0,0,0,0, 15, 3, 3, 0), 0);
        @(negedge clk);
        req_kind = 2'd1; req_rd = 0; req_data = 8'h5A; req_valid = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        repeat (3) @(negedge clk);
        check(req_ready == 0, "R9 not ready while busy", req_ready, 0);
        req_kind = 2'd2; req_valid = 1;
        repeat (3) @(negedge clk);
        req_valid = 0;
        dn = 0;
        for (int i = 0; i < 60; i++) begin
            if (done) dn++;
            @(negedge clk);
        end
        check(dn == 1, "R9 busy request ignored, one done", dn, 1);
        check(nand_ce_n == 1 && req_ready == 1, "R9 back to idle", nand_ce_n, 1);
    endtask

    task automatic t_force();
        do_cfg(32'h0, 1);
        @(negedge clk);
        check(nand_ce_n == 0, "R10 force ce low", nand_ce_n, 0);
        do_cfg(32'h0, 0);
        @(negedge clk);
        check(nand_ce_n == 1, "R10 force clear ce high", nand_ce_n, 1);
    endtask

    task automatic t_status();
        @(negedge clk);
        nand_rdy = 0;
        @(negedge clk);
        check(ready_stat == 1, "R11 status lag stage one", ready_stat, 1);
        @(negedge clk);
        check(ready_stat == 0, "R11 status low after two", ready_stat, 0);
        nand_rdy = 1;
        repeat (2) @(negedge clk);
        check(ready_stat == 1, "R11 status high again", ready_stat, 1);
    endtask

    task automatic t_poll();
        int k;
        do_cfg(tword(0,0,0,0, 0, 0, 0, 1), 0);
        nand_rdy = 0;
        repeat (3) @(negedge clk);
        req_kind = 2'd0; req_rd = 0; req_data = 8'h33; req_valid = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        k = 0;
        for (int i = 0; i < 12; i++) begin
            if (done) k++;
            @(negedge clk);
        end
        check(k == 0, "R5 no done while busy", k, 0);
        check(nand_ce_n == 0, "R5 cycle held during poll", nand_ce_n, 0);
        nand_rdy = 1;
        k = 0;
        while (!done && k < 20) begin
            @(negedge clk);
            k++;
        end
        check(k == 3, "R5 done after ready returns", k, 3);
    endtask

    task automatic t_soft();
        int pre, w, post, oe, cl, al, ceb, dqb;
        do_cfg(tword(0,0,0,0, 15, 15, 15, 15), 1);
        @(negedge clk);
        req_kind = 2'd1; req_rd = 0; req_data = 8'hC3; req_valid = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        repeat (20) @(negedge clk);
        soft_rst = 1;
        @(negedge clk);
        soft_rst = 0;
        check(req_ready == 1 && nand_we_n == 1 && nand_dq_oe == 0 && nand_cle == 0,
              "R12 abort to idle", req_ready, 1);
        check(nand_ce_n == 1, "R12 force cleared", nand_ce_n, 1);
        run_cycle(2'd0, 1, 8'h00, 8'hA5, pre, w, post, oe, cl, al, ceb, dqb);
        check(pre == 1 && w == 1 && post == 1, "R12 timing cleared",
              pre*100 + w*10 + post, 111);
        check(rd_data == 8'hA5, "R8 read after soft reset", rd_data, 8'hA5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        repeat (2) @(negedge clk);
        t_write(0, 0, 0, 0, 2'd1);
        t_write(15, 15, 15, 15, 2'd1);
        t_write($urandom_range(0,15), $urandom_range(0,15), $urandom_range(0,15), 0, 2'd2);
        t_write($urandom_range(0,15), $urandom_range(0,15), $urandom_range(0,15),
                $urandom_range(1,15), 2'd0);
        t_read(0, 0, 0, 0);
        t_read(15, 15, 15, 15);
        for (int i = 0; i < 4; i++)
            t_read($urandom_range(0,15), $urandom_range(0,15), $urandom_range(0,15),
                   $urandom_range(0,15));
        t_busy_ignore();
        t_force();
        t_status();
        t_poll();
        t_soft();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule